// File: doc/BRIEF.md
# Serial Flash Ready Poller

This block is the host side of a status check on a page-organised serial flash. It drives the chip-select, serial clock and data-out lines of an SPI link in mode 0, so the clock idles low and data is captured on the rising clock edge. A one-cycle start request opens a transaction: chip-select falls and the status-read command byte goes out, most significant bit first. After that the flash returns its status byte, and the block captures it and reports it with a one-cycle done pulse.

There are two modes. In single-read mode the block clocks in exactly one status byte and ends the transaction. In polling mode it parks the serial clock low as soon as the flash has driven the ready bit, the first status bit. It then watches the returned data line through a synchroniser. When the line goes high the clock resumes and the block reads the whole status byte of the now-ready device. If the line stays low for a set number of system cycles, the transaction ends with an error.

The serial clock half-period is a parameter that counts system clock cycles. Only the five upper status bits carry information, so the three low bits of the reported byte are always cleared.

Top module: `flash_ready_poller`

## Requirements
- R1: While chip-select is high the serial clock is low. Chip-select falls on the clock edge that accepts a start request, so it is seen low in the cycle after start_i is sampled high in idle.
- R2: The command byte 0x57 goes out on spi_mosi_o most significant bit first. The first bit is present from the moment chip-select falls, and each following bit is put out after a falling serial clock edge. Data-out stays 0 after the command byte and while idle, and it never changes while the serial clock is high.
- R3: Every serial clock edge occurs CLK_DIV system cycles after the previous edge, or after the moment chip-select fell or clocking resumed. A single-read transaction has exactly 16 rising edges.
- R4: The status byte is sampled from spi_miso_i on rising edges 9 to 16 of a transaction. The first sampled bit becomes status bit 7.
- R5: The reported status_o has bits 2..0 forced to 0. Bits 7..3 are the sampled values. status_o holds its value between done pulses.
- R6: In single-read mode, chip-select rises on the falling edge that follows rising edge 16, and done_o pulses high for exactly one cycle on that same clock edge.
- R7: In polling mode, once the falling edge after rising edge 8 has occurred, the serial clock stays low and chip-select stays low for as long as the synchronised data-in is 0.
- R8: Data-in passes through a two-stage synchroniser before the hold logic looks at it. When it reads 1, clocking resumes CLK_DIV cycles later and a full status byte is read and reported, with bit 7 equal to 1 (ready) and error_o low.
- R9: If the hold lasts TIMEOUT_CYCLES system cycles without a 1 being seen, chip-select rises, done_o and error_o pulse together, and status_o becomes 0x00.
- R10: A start request that arrives while a transaction is in progress is ignored. Each transaction produces exactly one done pulse.
- R11: error_o is never high without done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only while idle |
| poll_mode_i | input | 1 | 1 = wait for ready, 0 = single status read; sampled with start |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | One-cycle timeout flag, coincident with done_o |
| status_o | output | 8 | Last reported status, low three bits cleared |
| spi_cs_n_o | output | 1 | Flash chip-select, active low |
| spi_sck_o | output | 1 | Serial clock, idle low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
The hardest situation to reach is the parked-clock hold. It needs a flash that has already driven its ready bit as 0 and then raises that same line with no clock edge at all. The test device in the bench models this. It keeps a live status byte whose top bit comes from a busy countdown in system cycles, and it drives the currently selected bit straight onto data-in. A busy countdown shorter than the timeout shows the resume path and its synchroniser delay. A countdown longer than the timeout forces the error exit. Varying low-order status bits on every cycle show that the mask holds.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  localparam logic [7:0] RD_STATUS_OP    = 8'h57;
  localparam logic [7:0] STATUS_KEEP     = 8'hF8;
  localparam int unsigned EDGES_COMMAND  = 16;
  localparam int unsigned EDGES_TOTAL    = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } poll_state_e;

  // Command bit to present after a given number of SCK edges (0 past the command)
  function automatic logic cmd_bit(input logic [7:0] op, input logic [5:0] edges);
    logic [2:0] idx;
    if (edges >= 6'(EDGES_COMMAND)) return 1'b0;
    idx = 3'd7 - edges[3:1];
    return op[idx];
  endfunction

  // Only the upper five status bits are meaningful
  function automatic logic [7:0] keep_valid(input logic [7:0] raw);
    return raw & STATUS_KEEP;
  endfunction

endpackage

// File: rtl/poll_sck_divider.sv
module poll_sck_divider #(
  parameter int unsigned HALF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/poll_so_sync.sv
module poll_so_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/poll_shifter.sv
module poll_shifter
  import flash_poll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       fall_i,
  input  logic       rise_i,
  input  logic       capture_en_i,
  input  logic [5:0] edge_next_i,
  input  logic       miso_i,
  output logic       mosi_o,
  output logic [7:0] shreg_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mosi_o  <= 1'b0;
      shreg_o <= '0;
    end else if (load_i) begin
      mosi_o  <= cmd_bit(RD_STATUS_OP, 6'd0);
      shreg_o <= '0;
    end else begin
      if (fall_i)                 mosi_o  <= cmd_bit(RD_STATUS_OP, edge_next_i);
      if (rise_i && capture_en_i) shreg_o <= {shreg_o[6:0], miso_i};
    end
  end
endmodule

// File: rtl/flash_ready_poller.sv
module flash_ready_poller
  import flash_poll_pkg::*;
#(
  parameter int unsigned CLK_DIV        = 4,
  parameter int unsigned TIMEOUT_CYCLES = 100000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       poll_mode_i,
  output logic       done_o,
  output logic       error_o,
  output logic [7:0] status_o,
  output logic       spi_cs_n_o,
  output logic       spi_sck_o,
  output logic       spi_mosi_o,
  input  logic       spi_miso_i
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] WAIT_LAST = TW'(TIMEOUT_CYCLES - 1);

  poll_state_e state_q;
  logic        sck_q, cs_n_q, poll_q, done_q, err_q;
  logic [5:0]  edge_cnt_q;
  logic [TW-1:0] wait_cnt_q;
  logic [7:0]  status_q;

  // Named internal events
  logic       div_tick, evt_rise, evt_fall, evt_accept;
  logic       evt_finish_ok, evt_enter_hold, evt_resume, evt_timeout;
  logic       hold_active, so_ready;
  logic [5:0] edge_next;
  logic [7:0] shreg;

  poll_sck_divider #(.HALF_CYCLES(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_SHIFT), .tick_o(div_tick));

  poll_so_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(spi_miso_i), .q_o(so_ready));

  assign edge_next      = edge_cnt_q + 6'd1;
  assign evt_rise       = div_tick && !sck_q;
  assign evt_fall       = div_tick &&  sck_q;
  assign evt_accept     = (state_q == ST_IDLE) && start_i;
  assign evt_finish_ok  = evt_fall && (edge_next == 6'(EDGES_TOTAL));
  assign evt_enter_hold = evt_fall && poll_q && (edge_next == 6'(EDGES_COMMAND));
  assign hold_active    = (state_q == ST_HOLD);
  assign evt_resume     = hold_active && so_ready;
  assign evt_timeout    = hold_active && !so_ready && (wait_cnt_q == WAIT_LAST);

  poll_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .load_i(evt_accept), .fall_i(evt_fall), .rise_i(evt_rise),
    .capture_en_i(edge_cnt_q >= 6'(EDGES_COMMAND)),
    .edge_next_i(edge_next), .miso_i(spi_miso_i),
    .mosi_o(spi_mosi_o), .shreg_o(shreg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sck_q      <= 1'b0;
      cs_n_q     <= 1'b1;
      poll_q     <= 1'b0;
      edge_cnt_q <= '0;
      wait_cnt_q <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      status_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (evt_accept) begin
          state_q    <= ST_SHIFT;
          cs_n_q     <= 1'b0;
          sck_q      <= 1'b0;
          edge_cnt_q <= '0;
          poll_q     <= poll_mode_i;
        end
        ST_SHIFT: if (div_tick) begin
          sck_q      <= ~sck_q;
          edge_cnt_q <= edge_next;
          if (evt_finish_ok) begin
            state_q  <= ST_IDLE;
            cs_n_q   <= 1'b1;
            done_q   <= 1'b1;
            status_q <= keep_valid(shreg);
          end else if (evt_enter_hold) begin
            state_q    <= ST_HOLD;
            wait_cnt_q <= '0;
          end
        end
        ST_HOLD: begin
          if (evt_resume) begin
            state_q <= ST_SHIFT;
          end else if (evt_timeout) begin
            state_q  <= ST_IDLE;
            cs_n_q   <= 1'b1;
            done_q   <= 1'b1;
            err_q    <= 1'b1;
            status_q <= '0;
          end else begin
            wait_cnt_q <= wait_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o     = done_q;
  assign error_o    = err_q;
  assign status_o   = status_q;
  assign spi_cs_n_o = cs_n_q;
  assign spi_sck_o  = sck_q;

  a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n_o |-> !spi_sck_o);
  a_r1_cs_falls_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n_o && start_i) |=> !spi_cs_n_o);
  a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck_o && $past(spi_sck_o)) |-> $stable(spi_mosi_o));
  a_r3_sck_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !div_tick |=> $stable(spi_sck_o));
  a_r5_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (status_o[2:0] == 3'b000));
  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_hold_parks_clock: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> (!spi_sck_o && !spi_cs_n_o));
  a_r8_resume_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && so_ready) |=> (state_q == ST_SHIFT));
  a_r9_timeout_zero: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (status_o == 8'h00 && spi_cs_n_o));
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n_o && start_i && !done_o) |=> (edge_cnt_q >= $past(edge_cnt_q)));
  a_r11_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> done_o);
endmodule

// File: tb/flash_ready_poller_bench.sv
module flash_ready_poller_bench;
  localparam int HALF = 3;
  localparam int TMO  = 400;
  localparam logic [7:0] OPC = 8'h57;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, poll_mode_i = 1'b0;
  logic done_o, error_o, spi_cs_n_o, spi_sck_o, spi_mosi_o, spi_miso_i;
  logic [7:0] status_o;

  always #5 clk = ~clk;

  flash_ready_poller #(.CLK_DIV(HALF), .TIMEOUT_CYCLES(TMO)) u_flash_ready_poller (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .poll_mode_i(poll_mode_i),
    .done_o(done_o), .error_o(error_o), .status_o(status_o),
    .spi_cs_n_o(spi_cs_n_o), .spi_sck_o(spi_sck_o), .spi_mosi_o(spi_mosi_o),
    .spi_miso_i(spi_miso_i));

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- flash device model ----------------
  int   busy_left = 0;
  logic [3:0] dev_mid = 4'b0101;
  logic [2:0] dev_junk = 3'd0;
  logic [7:0] dev_opc = 8'h00;
  int   dev_bits = 0, dev_pos = 0, op_err = 0;
  bit   dev_out = 1'b0;
  logic [7:0] live;

  always @(posedge clk) begin
    dev_junk <= dev_junk + 3'd3;
    if (busy_left > 0) busy_left <= busy_left - 1;
  end
  assign live = {(busy_left == 0), dev_mid, dev_junk};
  assign spi_miso_i = (!spi_cs_n_o && dev_out) ? live[7 - dev_pos] : 1'b0;

  always @(posedge spi_cs_n_o) begin dev_bits = 0; dev_out = 0; dev_pos = 0; end
  always @(posedge spi_sck_o) if (!spi_cs_n_o && dev_bits < 8) begin
    dev_opc = {dev_opc[6:0], spi_mosi_o};
    dev_bits++;
  end
  always @(negedge spi_sck_o) if (!spi_cs_n_o) begin
    if (dev_out) dev_pos = (dev_pos + 1) % 8;
    else if (dev_bits == 8) begin
      dev_out = 1; dev_pos = 0;
      if (dev_opc != OPC) op_err++;
    end
  end

  // ---------------- behavioural reference ----------------
  bit m_active = 0, m_poll = 0, m_hold = 0;
  int m_cnt = 0, m_edges = 0, m_wcnt = 0;
  logic [7:0] m_sh = 0, e_status = 0;
  bit e_done = 0, e_err = 0;
  logic m_miso_s = 0;
  logic hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_hold = 0; e_done = 0; e_err = 0; e_status = 0; hist.delete();
    end else begin
      hist.push_front(m_miso_s);
      if (hist.size() > 3) void'(hist.pop_back());
      e_done = 0; e_err = 0;
      if (!m_active) begin
        if (start_i) begin
          m_active = 1; m_edges = 0; m_cnt = 0; m_poll = poll_mode_i; m_hold = 0; m_sh = 0;
        end
      end else if (m_hold) begin
        if (hist.size() > 2 && hist[2] === 1'b1) begin m_hold = 0; m_cnt = 0; end
        else if (m_wcnt == TMO - 1) begin
          m_active = 0; m_hold = 0; e_done = 1; e_err = 1; e_status = 0;
        end else m_wcnt++;
      end else begin
        m_cnt++;
        if (m_cnt == HALF) begin
          m_cnt = 0; m_edges++;
          if ((m_edges % 2 == 1) && m_edges > 16) m_sh = {m_sh[6:0], hist[0]};
          if (m_edges == 32) begin
            m_active = 0; e_done = 1; e_status = m_sh & 8'hF8;
          end else if (m_poll && m_edges == 16) begin
            m_hold = 1; m_wcnt = 0;
          end
        end
      end
    end
  end

  int done_cnt = 0, sck_rises = 0, low_run = 0, max_low_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_sck, e_mosi;
      e_sck  = m_active && (m_edges % 2 == 1);
      e_mosi = (m_active && m_edges < 16) ? OPC[7 - m_edges / 2] : 1'b0;
      chk(spi_cs_n_o === !m_active, "R1 cs_n", spi_cs_n_o, !m_active);
      chk(spi_sck_o === e_sck, "R3 sck", spi_sck_o, e_sck);
      chk(spi_mosi_o === e_mosi, "R2 mosi", spi_mosi_o, e_mosi);
      chk(done_o === e_done, "R6 done", done_o, e_done);
      chk(error_o === e_err, "R9 error", error_o, e_err);
      chk(status_o === e_status, "R5 status", status_o, e_status);
      if (done_o) done_cnt++;
      if (!spi_cs_n_o && !spi_sck_o) low_run++; else low_run = 0;
      if (low_run > max_low_run) max_low_run = low_run;
    end
    m_miso_s = spi_miso_i;
  end
  always @(posedge spi_sck_o) sck_rises++;

  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic run_txn(input bit poll, input int busy, input logic [3:0] mid,
                         output logic [7:0] st, output bit er);
    int guard = 0;
    @(negedge clk);
    busy_left = busy; dev_mid = mid; poll_mode_i = poll;
    sck_rises = 0; max_low_run = 0; done_cnt = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && guard < 5000) begin @(negedge clk); guard++; end
    chk(guard < 5000, "R6 done seen", guard, 0);
    st = status_o; er = error_o;
    repeat (4) @(negedge clk);
  endtask

  logic [7:0] st;
  bit er;
  initial begin
    repeat (4) @(negedge clk);
    chk(spi_cs_n_o === 1'b1 && spi_sck_o === 1'b0 && done_o === 1'b0, "R1 reset", spi_cs_n_o, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_txn(0, 0, 4'b1010, st, er);            // R4 ready device, single read
    chk(st == 8'hD0, "R4 single ready status", st, 8'hD0);
    chk(sck_rises == 16, "R3 rising edges", sck_rises, 16);
    chk(op_err == 0, "R2 opcode", op_err, 0);

    run_txn(0, 100000, 4'b0011, st, er);       // busy device reads bit7=0
    chk(st == 8'h18 && !er, "R6 single busy status", st, 8'h18);
    busy_left = 0;

    run_txn(1, 0, 4'b1111, st, er);            // R8 ready immediately
    chk(st == 8'hF8 && !er, "R8 poll ready status", st, 8'hF8);

    run_txn(1, 250, 4'b0110, st, er);          // R7 hold then resume
    chk(st == 8'hB0 && !er, "R8 poll resume status", st, 8'hB0);
    chk(max_low_run > 150, "R7 clock parked", max_low_run, 151);
    chk(sck_rises == 16, "R8 full byte after resume", sck_rises, 16);

    run_txn(1, 100000, 4'b0001, st, er);       // R9 timeout
    chk(er && st == 8'h00, "R9 timeout", {er, st}, 9'h100);
    busy_left = 0;

    // R10: extra start mid-transaction is ignored
    @(negedge clk);
    poll_mode_i = 1'b0; dev_mid = 4'b1000; done_cnt = 0;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (20) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (150) @(negedge clk);
    chk(done_cnt == 1, "R10 single done", done_cnt, 1);
    chk(status_o == 8'hC0, "R10 status", status_o, 8'hC0);
    chk(op_err == 0, "R2 opcode all", op_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_cmp++; n_bad++;
    $display("FAIL R6 watchdog actual=%0d expected=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule